// File: doc/BRIEF.md
# Memory-Side Loopback Training Responder

This block sits inside a memory device with a double-data-rate interface and answers the controller's interface-training sequences. A register-write command addressed to the loopback configuration register enables loopback, disables it, or changes its mode. Every new setting is first held as a pending value and takes over only after a fixed settling delay, so the echo never changes mode halfway through a command.

While loopback is active, the input cells deliver one rise-edge sample and one fall-edge sample per clock for each pin of the address, control and data-input groups. The block picks one group and transforms each pin's pair. In XOR mode the two samples are combined into a value that is the same in both half cycles, so the echo is single-rate and address/control pins can be trained first. In invert mode the rise sample is passed through and the fall sample is inverted, which turns single-rate input into double-rate output and the reverse, for read-data training.

The result leaves a fixed number of cycles after capture as a rise-half/fall-half pair for each output pin, ready for an external DDR output stage that is timed with the echo clock. The output is a pure stream with a valid flag and no ready: the far end cannot apply back-pressure, because the latency is part of the training contract. The output stage must accept every valid beat in the cycle it appears.

Top module: `lbk_responder`

## Requirements
- R1: The configuration register is written only when `cmd_wr` is high, `cmd_addr[3:0]` is 4'b0010 and `cmd_addr[9:7]` is 3'b000. `cmd_addr[i]` carries address bit i+1. A write to any other address leaves loopback unchanged.
- R2: In a qualifying write, `cmd_addr[4]` is the enable and `cmd_addr[6:5]` is the mode. Inputs captured from the 17th clock edge after the write's edge onward use the new setting. Inputs captured at earlier edges use the previous setting, and writing enable 0 turns loopback off under the same timing.
- R3: A qualifying write while a setting is pending replaces the pending value and restarts the 16-cycle delay.
- R4: Loopback is active only while the committed enable is 1 and `mrw_flag` is 0 in the capture cycle.
- R5: In XOR mode, both output halves of a pin equal rise sample XOR fall sample.
- R6: In invert mode, the rise half equals the rise sample and the fall half equals the inverted fall sample.
- R7: The mode code selects the echoed group as follows: 0 gives XOR on address, 1 gives XOR on control, 2 gives invert on address, and 3 gives invert on data-input.
- R8: A pair captured at clock edge k appears on `lb_rise`/`lb_fall` with `lb_valid` high after edge k+LBKL-1, which is LBKL cycles after it was presented.
- R9: After reset, loopback is disabled, `lb_valid` is low and both output halves are 0.
- R10: When `lb_valid` is low, `lb_rise` and `lb_fall` are all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Register-write command strobe |
| cmd_addr | input | 10 | Command address; bit i is address bit i+1 |
| mrw_flag | input | 1 | Mode-register-write flag; high suppresses loopback |
| adr_rise | input | GRP_W | Address group, rise-edge samples |
| adr_fall | input | GRP_W | Address group, fall-edge samples |
| ctl_rise | input | GRP_W | Control group, rise-edge samples |
| ctl_fall | input | GRP_W | Control group, fall-edge samples |
| din_rise | input | GRP_W | Data-input group, rise-edge samples |
| din_fall | input | GRP_W | Data-input group, fall-edge samples |
| lb_valid | output | 1 | Echo pair is valid this cycle |
| lb_rise | output | GRP_W | Echo value for the first half cycle |
| lb_fall | output | GRP_W | Echo value for the second half cycle |

## Verification
A configuration commit and a live echo stream can fall in the same cycle. The bench keeps sweeping all 256 rise/fall combinations while it issues mode changes, so the last capture under the old mode and the first under the new mode sit on adjacent edges. It judges every cycle against a bench-side model of when the commit lands. A second overlap, a rewrite that arrives while an earlier setting is still pending, is provoked five cycles after the first write and judged by the exact edge of the changeover.

// File: rtl/lbk_pkg.sv
package lbk_pkg;
  localparam int CMD_AW = 10;
  localparam logic [3:0] CFG_LO_SEL = 4'b0010;
  localparam logic [2:0] CFG_HI_SEL = 3'b000;

  typedef enum logic [1:0] {
    LB_XOR_ADR = 2'd0,
    LB_XOR_CTL = 2'd1,
    LB_INV_ADR = 2'd2,
    LB_INV_DIN = 2'd3
  } lb_mode_e;

  typedef struct packed {
    logic     en;
    lb_mode_e mode;
  } lb_cfg_t;
endpackage

// File: rtl/lbk_cfg_reg.sv
module lbk_cfg_reg
  import lbk_pkg::*;
#(
  parameter int SETTLE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [CMD_AW-1:0] cmd_addr,
  output logic              cfg_hit,
  output logic              cfg_pend,
  output lb_cfg_t           act_cfg
);
  localparam int CW = (SETTLE > 1) ? $clog2(SETTLE) : 1;
  localparam logic [CW-1:0] CNT_LOAD = CW'(SETTLE - 1);

  lb_cfg_t       pend_cfg;
  logic [CW-1:0] cnt;
  logic          commit;

  assign cfg_hit = cmd_wr && (cmd_addr[3:0] == CFG_LO_SEL) &&
                   (cmd_addr[9:7] == CFG_HI_SEL);
  assign commit  = cfg_pend && (cnt == '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_cfg  <= '0;
      pend_cfg <= '0;
      cfg_pend <= 1'b0;
      cnt      <= '0;
    end else begin
      if (commit) begin
        act_cfg  <= pend_cfg;
        cfg_pend <= 1'b0;
      end
      if (cfg_hit) begin
        pend_cfg.en   <= cmd_addr[4];
        pend_cfg.mode <= lb_mode_e'(cmd_addr[6:5]);
        cfg_pend      <= 1'b1;
        cnt           <= CNT_LOAD;
      end else if (cfg_pend && cnt != '0) begin
        cnt <= cnt - 1'b1;
      end
    end
  end
endmodule

// File: rtl/lbk_xform.sv
module lbk_xform
  import lbk_pkg::*;
#(
  parameter int W = 8
) (
  input  lb_cfg_t      cfg,
  input  logic         mrw_flag,
  input  logic [W-1:0] adr_rise,
  input  logic [W-1:0] adr_fall,
  input  logic [W-1:0] ctl_rise,
  input  logic [W-1:0] ctl_fall,
  input  logic [W-1:0] din_rise,
  input  logic [W-1:0] din_fall,
  output logic         x_vld,
  output logic [W-1:0] x_rise,
  output logic [W-1:0] x_fall
);
  logic [W-1:0] s_rise, s_fall;
  logic         inv;

  assign x_vld = cfg.en && !mrw_flag;
  assign inv   = (cfg.mode == LB_INV_ADR) || (cfg.mode == LB_INV_DIN);

  always_comb begin
    unique case (cfg.mode)
      LB_XOR_CTL: begin s_rise = ctl_rise; s_fall = ctl_fall; end
      LB_INV_DIN: begin s_rise = din_rise; s_fall = din_fall; end
      default:    begin s_rise = adr_rise; s_fall = adr_fall; end
    endcase
  end

  for (genvar p = 0; p < W; p++) begin : g_pin
    always_comb begin
      if (!x_vld) begin
        x_rise[p] = 1'b0;
        x_fall[p] = 1'b0;
      end else if (inv) begin
        x_rise[p] = s_rise[p];
        x_fall[p] = ~s_fall[p];
      end else begin
        x_rise[p] = s_rise[p] ^ s_fall[p];
        x_fall[p] = s_rise[p] ^ s_fall[p];
      end
    end
  end
endmodule

// File: rtl/lbk_pipe.sv
module lbk_pipe #(
  parameter int W   = 8,
  parameter int LAT = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         in_vld,
  input  logic [W-1:0] in_rise,
  input  logic [W-1:0] in_fall,
  output logic         head_vld,
  output logic         out_vld,
  output logic [W-1:0] out_rise,
  output logic [W-1:0] out_fall
);
  localparam int DW = 2 * W + 1;

  logic [DW-1:0] stg [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg[g] <= '0;
      end else if (g == 0) begin
        stg[g] <= {in_vld, in_rise, in_fall};
      end else begin
        stg[g] <= stg[(g == 0) ? 0 : g - 1];
      end
    end
  end

  assign head_vld = stg[0][DW-1];
  assign out_vld  = stg[LAT-1][DW-1];
  assign out_rise = stg[LAT-1][2*W-1:W];
  assign out_fall = stg[LAT-1][W-1:0];
endmodule

// File: rtl/lbk_responder.sv
module lbk_responder
  import lbk_pkg::*;
#(
  parameter int GRP_W  = 8,
  parameter int LBKL   = 4,
  parameter int SETTLE = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [9:0]       cmd_addr,
  input  logic             mrw_flag,
  input  logic [GRP_W-1:0] adr_rise,
  input  logic [GRP_W-1:0] adr_fall,
  input  logic [GRP_W-1:0] ctl_rise,
  input  logic [GRP_W-1:0] ctl_fall,
  input  logic [GRP_W-1:0] din_rise,
  input  logic [GRP_W-1:0] din_fall,
  output logic             lb_valid,
  output logic [GRP_W-1:0] lb_rise,
  output logic [GRP_W-1:0] lb_fall
);
  localparam int LAT_EFF = (LBKL < 1) ? 1 : LBKL;

  lb_cfg_t          act_cfg;
  logic             cfg_hit, cfg_pend, head_vld;
  logic             x_vld;
  logic [GRP_W-1:0] x_rise, x_fall;

  lbk_cfg_reg #(.SETTLE(SETTLE)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_n),
    .cmd_wr   (cmd_wr),
    .cmd_addr (cmd_addr),
    .cfg_hit  (cfg_hit),
    .cfg_pend (cfg_pend),
    .act_cfg  (act_cfg)
  );

  lbk_xform #(.W(GRP_W)) u_xf (
    .cfg      (act_cfg),
    .mrw_flag (mrw_flag),
    .adr_rise (adr_rise),
    .adr_fall (adr_fall),
    .ctl_rise (ctl_rise),
    .ctl_fall (ctl_fall),
    .din_rise (din_rise),
    .din_fall (din_fall),
    .x_vld    (x_vld),
    .x_rise   (x_rise),
    .x_fall   (x_fall)
  );

  lbk_pipe #(.W(GRP_W), .LAT(LAT_EFF)) u_pipe (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_vld   (x_vld),
    .in_rise  (x_rise),
    .in_fall  (x_fall),
    .head_vld (head_vld),
    .out_vld  (lb_valid),
    .out_rise (lb_rise),
    .out_fall (lb_fall)
  );
endmodule

// File: rtl/lbk_responder_chk.sv
module lbk_responder_chk
  import lbk_pkg::*;
#(
  parameter int GRP_W  = 8,
  parameter int SETTLE = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_hit,
  input logic             cfg_pend,
  input lb_cfg_t          act_cfg,
  input logic             mrw_flag,
  input logic             head_vld,
  input logic             lb_valid,
  input logic [GRP_W-1:0] lb_rise,
  input logic [GRP_W-1:0] lb_fall
);
  localparam int AW = $clog2(SETTLE + 2);
  localparam logic [AW-1:0] AGE_MAX = AW'(SETTLE);

  logic [AW-1:0] age;

  always_ff @(posedge clk) begin
    if (!rst_n) age <= AGE_MAX;
    else if (cfg_hit) age <= '0;
    else if (age != AGE_MAX) age <= age + 1'b1;
  end

  // R2: the committed setting changes only at the settling boundary
  a_r2_commit_age: assert property (@(posedge clk) disable iff (!rst_n)
    (act_cfg != $past(act_cfg)) |-> ($past(age) == AW'(SETTLE - 1)));

  // R2: with nothing pending, the committed setting holds
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_pend |=> $stable(act_cfg));

  // R3: every qualifying write leaves a pending setting
  a_r3_pending: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_hit |=> cfg_pend);

  // R4: inactive capture produces an invalid beat
  a_r4_inactive: assert property (@(posedge clk) disable iff (!rst_n)
    (mrw_flag || !act_cfg.en) |=> !head_vld);

  // R10: invalid output drives zeros
  a_r10_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lb_valid |-> (lb_rise == '0 && lb_fall == '0));
endmodule

bind lbk_responder lbk_responder_chk #(.GRP_W(GRP_W), .SETTLE(SETTLE)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_hit  (cfg_hit),
  .cfg_pend (cfg_pend),
  .act_cfg  (act_cfg),
  .mrw_flag (mrw_flag),
  .head_vld (head_vld),
  .lb_valid (lb_valid),
  .lb_rise  (lb_rise),
  .lb_fall  (lb_fall)
);

// File: tb/lbk_responder_tb.sv
module lbk_responder_tb;
  localparam int W      = 4;
  localparam int LAT    = 4;
  localparam int SETTLE = 16;
  localparam int NCYC   = 2048;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         cmd_wr = 1'b0;
  logic [9:0]   cmd_addr = '0;
  logic         mrw_flag = 1'b0;
  logic [W-1:0] adr_rise = '0, adr_fall = '0, ctl_rise = '0, ctl_fall = '0;
  logic [W-1:0] din_rise = '0, din_fall = '0;
  logic         lb_valid;
  logic [W-1:0] lb_rise, lb_fall;

  always #5 clk = ~clk;

  lbk_responder #(.GRP_W(W), .LBKL(LAT), .SETTLE(SETTLE)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_addr(cmd_addr),
    .mrw_flag(mrw_flag), .adr_rise(adr_rise), .adr_fall(adr_fall),
    .ctl_rise(ctl_rise), .ctl_fall(ctl_fall), .din_rise(din_rise),
    .din_fall(din_fall), .lb_valid(lb_valid), .lb_rise(lb_rise),
    .lb_fall(lb_fall)
  );

  int n_run = 0, n_fail = 0;
  bit done = 1'b0;

  // bench-side model of the committed and pending setting
  bit       m_en = 0;
  bit [1:0] m_mode = 0;
  bit       p_on = 0, p_en = 0;
  bit [1:0] p_mode = 0;
  int       p_w = 0;
  int       j = 0;
  int       first_vld = -1;
  bit       watch = 0;

  // stimulus staged by the caller for the next step
  bit       b_wr = 0, b_mrw = 0;
  bit [9:0] b_addr = 0;
  string    ph_tag = "R10";

  bit           e_v [NCYC];
  logic [W-1:0] e_r [NCYC];
  logic [W-1:0] e_f [NCYC];
  string        e_t [NCYC];

  function automatic bit [9:0] mk_addr(bit en, bit [1:0] mode);
    return {3'b000, mode, en, 4'b0010};
  endfunction

  task automatic check(string tag, int got, int exp);
    n_run++;
    if (got != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, got, exp, j);
    end
  endtask

  task automatic step();
    bit [7:0]     k;
    bit [W-1:0]   sr, sf;
    bit           act;
    @(negedge clk);
    if (j >= LAT && j - LAT < NCYC)
      check(e_t[j-LAT], {lb_valid, lb_rise, lb_fall},
            {e_v[j-LAT], e_r[j-LAT], e_f[j-LAT]});
    if (watch && lb_valid && first_vld < 0) first_vld = j;
    if (p_on && j >= p_w + SETTLE + 1) begin
      m_en = p_en; m_mode = p_mode; p_on = 0;
    end
    k = j[7:0];
    cmd_wr = b_wr; cmd_addr = b_addr; mrw_flag = b_mrw;
    adr_rise = k[3:0];          adr_fall = k[7:4];
    ctl_rise = k[3:0] ^ 4'h5;   ctl_fall = k[7:4] ^ 4'hA;
    din_rise = ~k[3:0];         din_fall = k[7:4] ^ 4'h3;
    if (b_wr && b_addr[3:0] == 4'b0010 && b_addr[9:7] == 3'b000) begin
      p_on = 1; p_w = j; p_en = b_addr[4]; p_mode = b_addr[6:5];
    end
    act = m_en && !b_mrw;
    case (m_mode)
      2'd1:    begin sr = ctl_rise; sf = ctl_fall; end
      2'd3:    begin sr = din_rise; sf = din_fall; end
      default: begin sr = adr_rise; sf = adr_fall; end
    endcase
    if (j < NCYC) begin
      e_v[j] = act;
      e_t[j] = ph_tag;
      if (!act) begin e_r[j] = '0; e_f[j] = '0; end
      else if (m_mode[1]) begin e_r[j] = sr; e_f[j] = ~sf; end
      else begin e_r[j] = sr ^ sf; e_f[j] = sr ^ sf; end
    end
    j++;
  endtask

  task automatic idle(int n);
    b_wr = 0;
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic write(bit [9:0] a);
    b_wr = 1; b_addr = a;
    step();
    b_wr = 0;
  endtask

  initial begin
    int w_en;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", {lb_valid, lb_rise, lb_fall}, 0);
    rst_n = 1'b1;

    ph_tag = "R10"; idle(8);

    // R1: writes to other addresses are ignored
    ph_tag = "R1";
    write({3'b001, 2'd0, 1'b1, 4'b0010});
    write({3'b000, 2'd0, 1'b1, 4'b0011});
    write({3'b100, 2'd2, 1'b1, 4'b0010});
    idle(30);

    // R2 R8: enable XOR on address, exact first valid beat
    ph_tag = "R2 R8";
    watch = 1; first_vld = -1; w_en = j;
    write(mk_addr(1, 2'd0));
    idle(22);
    check("R8", first_vld, w_en + SETTLE + 1 + LAT);
    watch = 0;
    ph_tag = "R5 R7"; idle(256);

    // R2: change to XOR on control while streaming; old mode holds meanwhile
    ph_tag = "R2";
    write(mk_addr(1, 2'd1));
    idle(20);
    ph_tag = "R5 R7"; idle(256);

    // R3: rewrite while pending restarts the delay
    ph_tag = "R3";
    write(mk_addr(1, 2'd2));
    idle(4);
    write(mk_addr(1, 2'd3));
    idle(30);
    ph_tag = "R6 R7"; idle(256);

    ph_tag = "R2";
    write(mk_addr(1, 2'd2));
    idle(20);
    ph_tag = "R6 R7"; idle(256);

    // R4: mode-register-write flag suppresses loopback
    ph_tag = "R4";
    b_mrw = 1; idle(20);
    b_mrw = 0; idle(10);

    // R2 R10: disable
    ph_tag = "R2 R10";
    write(mk_addr(0, 2'd2));
    idle(40);
    check("R10", lb_valid, 0);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule